// File: doc/BRIEF.md
# Nibble-Multiplexed IQ Receive Output

This block carries paired 8-bit in-phase (I) and quadrature (Q) samples from two receive converters off chip over a narrow 4-bit bus. Each pair forms one symbol of four nibbles. The nibbles go out on four consecutive master-clock cycles in a fixed order: I upper, I lower, Q upper, Q lower. A frame sync line is high during the first of those cycles, so a receiver can align to the symbol boundary without any other signalling.

An upstream source offers a pair with a one-cycle valid strobe. The pair waits in a holding register. The sequencer copies it into the active pair register only when a new symbol starts, so a symbol never mixes halves from two samples. When no new pair has arrived by a boundary, the sequencer sends the last pair again. Before the first pair arrives, the bus stays at zero and sync stays low.

The sequencer has five states. `ST_IDLE` is the state after reset. It moves to `ST_IHI` once a pair is held, loading that pair. The states then step `ST_IHI` to `ST_ILO` to `ST_QHI` to `ST_QLO` on every clock. `ST_QLO` always returns to `ST_IHI`. On that step it loads the held pair if a new one is waiting, and otherwise keeps the current pair.

Top module: `iq_nibble_tx`

## Requirements
- R1: From reset until the cycle after the first sampled `in_valid`, `nib_o` is 0 and `sync_o` is 0.
- R2: If `in_valid` is first sampled high at clock edge n, the I upper nibble of that pair is on `nib_o`, with `sync_o` high, from edge n+1.
- R3: A symbol places `i_in[7:4]`, `i_in[3:0]`, `q_in[7:4]` and `q_in[3:0]` of one pair on `nib_o` in four consecutive cycles, in that order.
- R4: `sync_o` is high only in the cycle that carries the I upper nibble, and low in the three cycles that follow it.
- R5: Once started, symbols follow one another with no gap, so `sync_o` is high every fourth cycle.
- R6: A pair that arrives during a symbol does not change that symbol. It is sent in the next symbol.
- R7: If no new pair arrived during a symbol, the next symbol repeats the previous pair.
- R8: If several pairs arrive within one symbol, only the last of them is sent.
- R9: A pair sampled at the same edge that starts a new symbol is not part of that symbol. That symbol carries the earlier held or repeated pair, and the new pair follows in the symbol after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: `i_in` and `q_in` carry a new pair |
| i_in | input | 8 | In-phase sample |
| q_in | input | 8 | Quadrature sample |
| nib_o | output | 4 | Nibble bus |
| sync_o | output | 1 | Frame sync, high with the I upper nibble |

## Verification
The hardest case to reach from the ports is a pair that arrives on the exact edge where `ST_QLO` returns to `ST_IHI`. Here the load and a new capture happen together, and the result depends on which of them wins. The bench lines up with sync and counts three falling edges to reach the last nibble cycle. It raises the strobe there, and it only queues the expected pair after the next sync has been consumed. The scoreboard must therefore see one repeated symbol and then the new pair. The bench also checks mid-symbol arrivals and two arrivals in one symbol in the same aligned way.

// File: rtl/iqn_pkg.sv
package iqn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_IHI  = 3'd1,
        ST_ILO  = 3'd2,
        ST_QHI  = 3'd3,
        ST_QLO  = 3'd4
    } iqn_state_e;

endpackage

// File: rtl/iqn_hold.sv
// Holding register: keeps the most recent offered pair and a flag that a
// pair is waiting for the next symbol boundary.
module iqn_hold #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] i_in,
    input  logic [SAMPLE_W-1:0] q_in,
    input  logic                take,
    output logic [SAMPLE_W-1:0] hold_i,
    output logic [SAMPLE_W-1:0] hold_q,
    output logic                hold_new
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_i   <= '0;
            hold_q   <= '0;
            hold_new <= 1'b0;
        end else begin
            if (in_valid) begin
                hold_i   <= i_in;
                hold_q   <= q_in;
                hold_new <= 1'b1;
            end else if (take) begin
                hold_new <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/iqn_seq.sv
// Symbol sequencer: idle until a pair is held, then four nibble slots per symbol.
module iqn_seq
    import iqn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_new,
    output iqn_state_e state,
    output logic       load
);

    iqn_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (hold_new) begin
                    state_nx = ST_IHI;
                    load     = 1'b1;
                end
            end
            ST_IHI: state_nx = ST_ILO;
            ST_ILO: state_nx = ST_QHI;
            ST_QHI: state_nx = ST_QLO;
            ST_QLO: begin
                state_nx = ST_IHI;
                load     = hold_new;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/iqn_active.sv
// Active pair register: changes only at a symbol start.
module iqn_active #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] hold_i,
    input  logic [SAMPLE_W-1:0] hold_q,
    output logic [SAMPLE_W-1:0] act_i,
    output logic [SAMPLE_W-1:0] act_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_i <= '0;
            act_q <= '0;
        end else if (load) begin
            act_i <= hold_i;
            act_q <= hold_q;
        end
    end

endmodule

// File: rtl/iqn_nib_mux.sv
// Output process: selects the nibble for the current slot and drives sync.
module iqn_nib_mux
    import iqn_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    localparam int NIB_W   = SAMPLE_W / 2
) (
    input  iqn_state_e          state,
    input  logic [SAMPLE_W-1:0] act_i,
    input  logic [SAMPLE_W-1:0] act_q,
    output logic [NIB_W-1:0]    nib,
    output logic                sync
);

    logic [NIB_W-1:0] i_hi, i_lo, q_hi, q_lo;

    assign i_hi = act_i[SAMPLE_W-1:NIB_W];
    assign i_lo = act_i[NIB_W-1:0];
    assign q_hi = act_q[SAMPLE_W-1:NIB_W];
    assign q_lo = act_q[NIB_W-1:0];

    always_comb begin
        nib  = '0;
        sync = 1'b0;
        unique case (state)
            ST_IDLE: begin
                nib  = '0;
                sync = 1'b0;
            end
            ST_IHI: begin
                nib  = i_hi;
                sync = 1'b1;
            end
            ST_ILO: nib = i_lo;
            ST_QHI: nib = q_hi;
            ST_QLO: nib = q_lo;
            default: nib = '0;
        endcase
    end

endmodule

// File: rtl/iq_nibble_tx.sv
module iq_nibble_tx
    import iqn_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    localparam int NIB_W   = SAMPLE_W / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] i_in,
    input  logic [SAMPLE_W-1:0] q_in,
    output logic [NIB_W-1:0]    nib_o,
    output logic                sync_o
);

    logic [SAMPLE_W-1:0] hold_i, hold_q, act_i, act_q;
    logic                hold_new, load;
    iqn_state_e          state;

    iqn_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .i_in(i_in), .q_in(q_in), .take(load),
        .hold_i(hold_i), .hold_q(hold_q), .hold_new(hold_new)
    );

    iqn_seq u_seq (
        .clk(clk), .rst_n(rst_n), .hold_new(hold_new),
        .state(state), .load(load)
    );

    iqn_active #(.SAMPLE_W(SAMPLE_W)) u_active (
        .clk(clk), .rst_n(rst_n), .load(load),
        .hold_i(hold_i), .hold_q(hold_q),
        .act_i(act_i), .act_q(act_q)
    );

    iqn_nib_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
        .state(state), .act_i(act_i), .act_q(act_q),
        .nib(nib_o), .sync(sync_o)
    );

endmodule

// File: rtl/iqn_chk.sv
module iqn_chk #(
    parameter int SAMPLE_W = 8,
    localparam int NIB_W   = SAMPLE_W / 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] i_in,
    input logic [NIB_W-1:0]    nib_o,
    input logic                sync_o
);

    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= seen | in_valid;
    end

    // R1
    quiet_before_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (nib_o == '0 && !sync_o));

    // R2
    first_symbol_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !seen) |-> ##2 (sync_o && nib_o == $past(i_in[SAMPLE_W-1:NIB_W], 2)));

    // R4
    sync_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> !sync_o);

    // R5
    sync_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_o, 4) |-> sync_o);

endmodule

bind iq_nibble_tx iqn_chk #(.SAMPLE_W(SAMPLE_W)) u_iqn_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .i_in(i_in), .nib_o(nib_o), .sync_o(sync_o)
);

// File: tb/test_iq_nibble_tx.sv
module test_iq_nibble_tx;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] i_in = '0;
    logic [7:0] q_in = '0;
    logic [3:0] nib_o;
    logic       sync_o;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_tag = "R3";

    logic [15:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_nibble_tx i_iq_nibble_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .i_in(i_in), .q_in(q_in), .nib_o(nib_o), .sync_o(sync_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver: offers a pair for one cycle, optionally queueing it as expected.
    task automatic send(input logic [7:0] iv, input logic [7:0] qv, input bit push);
        i_in     = iv;
        q_in     = qv;
        in_valid = 1'b1;
        if (push) exp_q.push_back({iv, qv});
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (!sync_o);
    endtask

    // Monitor / scoreboard
    bit          started = 1'b0;
    int          pos = 0;
    logic [15:0] cur = '0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sync_o) begin
                // R5: gap between syncs must be exactly four cycles
                if (started) chk(pos == 3, "R5 sync spacing", pos + 1, 4);
                // R6, R7: pop a new pair, or expect a repeat
                if (exp_q.size() > 0) cur = exp_q.pop_front();
                started = 1'b1;
                pos = 0;
                chk(nib_o == cur[15:12], {cur_tag, " R3 I upper"}, nib_o, cur[15:12]);
            end else if (started) begin
                pos++;
                // R4: sync absent only in the three following slots
                chk(pos <= 3, "R5 missing sync", pos, 3);
                if (pos == 1) chk(nib_o == cur[11:8], {cur_tag, " R3 I lower"}, nib_o, cur[11:8]);
                if (pos == 2) chk(nib_o == cur[7:4],  {cur_tag, " R3 Q upper"}, nib_o, cur[7:4]);
                if (pos == 3) chk(nib_o == cur[3:0],  {cur_tag, " R3 Q lower"}, nib_o, cur[3:0]);
            end else begin
                // R1: quiet until started
                chk(nib_o == 4'h0, "R1 idle bus", nib_o, 0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(nib_o == 4'h0 && sync_o == 1'b0, "R1 in reset", {sync_o, nib_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: first pair, timing from the sampling edge
        cur_tag = "R2";
        send(8'hA5, 8'h3C, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(sync_o == 1'b0 && nib_o == 4'h0, "R1 one edge after capture", {sync_o, nib_o}, 0);
        @(negedge clk);
        chk(sync_o == 1'b1 && nib_o == 4'hA, "R2 first I upper", {sync_o, nib_o}, 5'h1A);

        // R6: new pairs offered mid-symbol, one per symbol
        cur_tag = "R6";
        for (int k = 0; k < 3; k++) begin
            wait_sync();
            @(negedge clk);
            send(8'h1E + 8'(k * 17), 8'hC7 - 8'(k * 35), 1'b1);
            @(negedge clk);
            in_valid = 1'b0;
        end

        // R7: nothing new for several symbols
        wait_sync();
        cur_tag = "R7";
        repeat (3) wait_sync();

        // R8: two pairs in one symbol, the later one wins
        cur_tag = "R8";
        wait_sync();
        @(negedge clk);
        send(8'h55, 8'h66, 1'b0);
        @(negedge clk);
        send(8'h9B, 8'h2F, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;

        // R9: pair sampled on the boundary edge
        wait_sync();
        cur_tag = "R9";
        repeat (3) @(negedge clk);
        chk(sync_o == 1'b0 && nib_o == 4'hF, "R9 in last slot", {sync_o, nib_o}, 5'h0F);
        send(8'hE4, 8'h71, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk(sync_o == 1'b1 && nib_o == 4'h9, "R9 boundary symbol repeats", {sync_o, nib_o}, 5'h19);
        #1 exp_q.push_back({8'hE4, 8'h71});
        repeat (3) wait_sync();
        chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL R5 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule